// File: doc/BRIEF.md
# Configurable Asynchronous Serial Transmitter

This block turns bytes into asynchronous serial frames on one output line. A host writes a byte into a one-entry holding register with a single-cycle strobe. When the frame engine is idle, it moves the byte into its shift register and sends a frame:

- a low start bit;
- the data bits, least-significant first;
- an optional parity bit;
- a high stop period.

The line rests high between frames. A configuration byte sets the frame format: data length, stop length and parity style. A further bit of that byte forces the line low to signal a break.

Timing comes from an external tick input, one pulse per half bit. Every bit therefore lasts two ticks, and a stop period of one and a half bits lasts exactly three ticks. Two status flags are provided. One reports that the holding register can accept a byte. The other reports that nothing is left to send.

The frame engine is a five-state machine:

- `ST_IDLE` → `ST_START`: a byte is waiting. The byte is loaded and the format is captured.
- `ST_START` → `ST_DATA`: after two ticks.
- `ST_DATA` → `ST_DATA`: each data bit after two ticks, while data bits remain.
- `ST_DATA` → `ST_PARITY`: after the last data bit, when parity is enabled.
- `ST_DATA` → `ST_STOP`: after the last data bit, when parity is disabled.
- `ST_PARITY` → `ST_STOP`: after two ticks.
- `ST_STOP` → `ST_IDLE`: after the chosen number of half-bit ticks.

Top module: `async_tx_serializer`

## Requirements
- R1: `line_cfg[1:0]` selects the number of data bits sent: 0 gives 5, 1 gives 6, 2 gives 7 and 3 gives 8. Only that many low bits of the byte appear on the line.
- R2: With `line_cfg[2]` clear, the stop period is 2 ticks. With it set, the stop period is 3 ticks for 5-bit data and 4 ticks for longer data. Start, data and parity bits each last 2 ticks.
- R3: `line_cfg[5:3]` selects parity. When bit 3 is clear, no parity bit is sent. The enabled codes are:
  - 001: odd (the data ones plus the parity bit total an odd count);
  - 011: even;
  - 101: parity bit fixed at 1;
  - 111: parity bit fixed at 0.
- R4: While `line_cfg[6]` is 1, `txd` is 0 whether the engine is idle or mid-frame. The frame timing continues underneath the break.
- R5: `hold_empty` falls in the cycle after `wr_en`. It rises when the byte moves into the shifter.
- R6: `tx_empty` is 1 only when the holding register and the shifter are both empty. It stays 0 through a frame and while a byte waits.
- R7: A frame sends a 0 start bit, the data LSB first, the parity bit if enabled, then stop bits at 1. `txd` is 1 when idle. Ticks while idle have no effect.
- R8: A waiting byte is loaded only from the idle state, one clock after the idle state is entered. The format in force at load time applies to the whole frame. Later changes to `line_cfg[5:0]` affect only the next frame.
- R9: After reset, `txd`, `hold_empty` and `tx_empty` are all 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| line_cfg | input | 7 | Frame format: length [1:0], stop [2], parity [5:3], break [6] |
| tick | input | 1 | Half-bit timing pulse, one clock wide |
| wr_en | input | 1 | Write strobe for the holding register |
| wr_data | input | 8 | Byte to send |
| txd | output | 1 | Serial output line |
| hold_empty | output | 1 | Holding register can accept a byte |
| tx_empty | output | 1 | Holding register and shifter both empty |

## Verification
A wrong state or counter in the frame engine shows up on `txd` within two ticks. A skipped or repeated state shifts every later half-bit sample of the frame. A wrong stop count moves the rise of `tx_empty` by at least one tick. A fault in the holding register appears on `hold_empty` within one clock of a write or a load. A byte captured or loaded at the wrong time corrupts the data bits of the frame that follows. A format latched at the wrong moment is exposed by the back-to-back case, in which the configuration changes between two frames.

// File: rtl/txser_pkg.sv
package txser_pkg;

    localparam int LEN_W  = 4;
    localparam int SLOT_W = 3;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_START,
        ST_DATA,
        ST_PARITY,
        ST_STOP
    } txs_state_t;

    typedef struct packed {
        logic [LEN_W-1:0]  nbits;
        logic [SLOT_W-1:0] stop_halves;
        logic              par_en;
        logic              par_bit;
    } frame_cfg_t;

endpackage

// File: rtl/txser_hold.sv
module txser_hold #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_i,
    input  logic [DATA_W-1:0] wr_data_i,
    input  logic              take_i,
    output logic              full_o,
    output logic [DATA_W-1:0] data_o
);

    logic              full_q;
    logic [DATA_W-1:0] data_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            full_q <= 1'b0;
            data_q <= '0;
        end else begin
            if (wr_i) begin
                full_q <= 1'b1;
                data_q <= wr_data_i;
            end else if (take_i) begin
                full_q <= 1'b0;
            end
        end
    end

    always_comb begin
        full_o = full_q;
        data_o = data_q;
    end

    // R5: a write leaves the register occupied on the following cycle
    a_r5_write_fills: assert property (@(posedge clk) disable iff (!rst_n)
        wr_i |=> full_o);

    // R8: the byte is taken only while it is present
    a_r8_take_needs_data: assert property (@(posedge clk) disable iff (!rst_n)
        take_i |-> full_q);

endmodule

// File: rtl/txser_cfg_decode.sv
module txser_cfg_decode
    import txser_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic [5:0]        fmt_i,
    input  logic [DATA_W-1:0] data_i,
    output frame_cfg_t        cfg_o
);

    localparam logic [LEN_W-1:0] MIN_LEN = LEN_W'(DATA_W - 3);

    logic [LEN_W-1:0] nbits;
    logic             ones_odd;

    always_comb begin
        nbits = MIN_LEN + {2'b00, fmt_i[1:0]};
    end

    always_comb begin
        ones_odd = 1'b0;
        for (int i = 0; i < DATA_W; i++) begin
            if (i < int'(nbits)) begin
                ones_odd = ones_odd ^ data_i[i];
            end
        end
    end

    always_comb begin
        cfg_o.nbits = nbits;
        if (!fmt_i[2]) begin
            cfg_o.stop_halves = 3'd2;
        end else if (fmt_i[1:0] == 2'b00) begin
            cfg_o.stop_halves = 3'd3;
        end else begin
            cfg_o.stop_halves = 3'd4;
        end
        cfg_o.par_en = fmt_i[3];
        if (fmt_i[5]) begin
            cfg_o.par_bit = ~fmt_i[4];
        end else if (fmt_i[4]) begin
            cfg_o.par_bit = ones_odd;
        end else begin
            cfg_o.par_bit = ~ones_odd;
        end
    end

endmodule

// File: rtl/txser_fsm.sv
module txser_fsm
    import txser_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_i,
    input  logic              hold_full_i,
    input  logic [DATA_W-1:0] hold_data_i,
    input  frame_cfg_t        cfg_i,
    output logic              load_o,
    output logic              busy_o,
    output logic              line_o
);

    txs_state_t        state_q, state_d;
    logic [DATA_W-1:0] shift_q, shift_d;
    logic [LEN_W-1:0]  left_q,  left_d;
    logic [SLOT_W-1:0] slot_q,  slot_d;
    frame_cfg_t        cfg_q,   cfg_d;
    logic [SLOT_W-1:0] limit;
    logic              slot_end;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            shift_q <= '0;
            left_q  <= '0;
            slot_q  <= '0;
            cfg_q   <= '0;
        end else begin
            state_q <= state_d;
            shift_q <= shift_d;
            left_q  <= left_d;
            slot_q  <= slot_d;
            cfg_q   <= cfg_d;
        end
    end

    always_comb begin
        limit    = (state_q == ST_STOP) ? cfg_q.stop_halves : 3'd2;
        slot_end = tick_i && ((slot_q + 3'd1) == limit);
        state_d  = state_q;
        shift_d  = shift_q;
        left_d   = left_q;
        slot_d   = slot_q;
        cfg_d    = cfg_q;
        if (state_q != ST_IDLE && tick_i) begin
            slot_d = slot_end ? '0 : slot_q + 3'd1;
        end
        unique case (state_q)
            ST_IDLE: begin
                if (hold_full_i) begin
                    state_d = ST_START;
                    shift_d = hold_data_i;
                    cfg_d   = cfg_i;
                    slot_d  = '0;
                end
            end
            ST_START: begin
                if (slot_end) begin
                    state_d = ST_DATA;
                    left_d  = cfg_q.nbits;
                end
            end
            ST_DATA: begin
                if (slot_end) begin
                    shift_d = shift_q >> 1;
                    left_d  = left_q - 4'd1;
                    if (left_q == 4'd1) begin
                        state_d = cfg_q.par_en ? ST_PARITY : ST_STOP;
                    end
                end
            end
            ST_PARITY: begin
                if (slot_end) begin
                    state_d = ST_STOP;
                end
            end
            ST_STOP: begin
                if (slot_end) begin
                    state_d = ST_IDLE;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        load_o = (state_q == ST_IDLE) && hold_full_i;
        busy_o = (state_q != ST_IDLE);
        unique case (state_q)
            ST_IDLE:   line_o = 1'b1;
            ST_START:  line_o = 1'b0;
            ST_DATA:   line_o = shift_q[0];
            ST_PARITY: line_o = cfg_q.par_bit;
            ST_STOP:   line_o = 1'b1;
            default:   line_o = 1'b1;
        endcase
    end

    // R8: a load opens a frame with a low start bit
    a_r8_load_starts_frame: assert property (@(posedge clk) disable iff (!rst_n)
        load_o |=> (state_q == ST_START && !line_o));

    // R7: without a tick an active frame does not change state
    a_r7_hold_without_tick: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick_i && state_q != ST_IDLE) |=> $stable(state_q));

    // R2: the stop half-bit count stays below the latched stop length
    a_r2_stop_bound: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_STOP) |-> (slot_q < cfg_q.stop_halves));

    // R1: data bits remaining never exceed the latched length
    a_r1_len_bound: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_DATA) |-> (left_q != 4'd0 && left_q <= cfg_q.nbits));

endmodule

// File: rtl/async_tx_serializer.sv
module async_tx_serializer
    import txser_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [6:0]        line_cfg,
    input  logic              tick,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    output logic              txd,
    output logic              hold_empty,
    output logic              tx_empty
);

    logic              hold_full;
    logic [DATA_W-1:0] hold_data;
    logic              load;
    logic              busy;
    logic              line;
    frame_cfg_t        cfg_now;

    txser_hold #(.DATA_W(DATA_W)) hold_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_i      (wr_en),
        .wr_data_i (wr_data),
        .take_i    (load),
        .full_o    (hold_full),
        .data_o    (hold_data)
    );

    txser_cfg_decode #(.DATA_W(DATA_W)) dec_i (
        .fmt_i  (line_cfg[5:0]),
        .data_i (hold_data),
        .cfg_o  (cfg_now)
    );

    txser_fsm #(.DATA_W(DATA_W)) fsm_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .tick_i      (tick),
        .hold_full_i (hold_full),
        .hold_data_i (hold_data),
        .cfg_i       (cfg_now),
        .load_o      (load),
        .busy_o      (busy),
        .line_o      (line)
    );

    always_comb begin
        txd        = line_cfg[6] ? 1'b0 : line;
        hold_empty = ~hold_full;
        tx_empty   = ~hold_full & ~busy;
    end

    // R6: nothing pending means the holding register is empty too
    a_r6_empty_order: assert property (@(posedge clk) disable iff (!rst_n)
        tx_empty |-> hold_empty);

    // R7: an idle engine without break drives the line high
    a_r7_idle_high: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !line_cfg[6]) |-> txd);

    // R5: a write clears the empty flag on the next cycle
    a_r5_write_clears: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> !hold_empty);

endmodule

// File: tb/async_tx_serializer_tb_top.sv
module async_tx_serializer_tb_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [6:0] line_cfg = 7'h03;
    logic       tick = 1'b0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic       txd, hold_empty, tx_empty;

    int total = 0;
    int bad = 0;
    bit done = 0;

    always #10 clk = ~clk;

    async_tx_serializer dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .line_cfg   (line_cfg),
        .tick       (tick),
        .wr_en      (wr_en),
        .wr_data    (wr_data),
        .txd        (txd),
        .hold_empty (hold_empty),
        .tx_empty   (tx_empty)
    );

    // {cfg, data}
    localparam logic [15:0] VEC [9] = '{
        16'h03A5, 16'h0413, 16'h1E5B, 16'h092C, 16'h2F81,
        16'h381F, 16'h053A, 16'h13C6, 16'h1B7E
    };

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic pulse_tick();
        @(negedge clk) tick = 1'b1;
        @(negedge clk) tick = 1'b0;
        repeat (2) @(negedge clk);
    endtask

    task automatic write_byte(input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1;
        wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
        check(hold_empty == 1'b0, "R5", "empty after write", hold_empty, 0);
        check(tx_empty == 1'b0, "R6", "tx_empty after write", tx_empty, 0);
    endtask

    // expected line value for each half-bit slot, from R1, R2, R3, R7
    function automatic int build(input logic [7:0] cfg, input logic [7:0] d,
                                 output logic [31:0] sl);
        int n = 0;
        int nb = 5 + int'(cfg[1:0]);
        int ones = 0;
        logic p;
        sl = '1;
        sl[n++] = 1'b0;
        sl[n++] = 1'b0;
        for (int i = 0; i < nb; i++) begin
            sl[n++] = d[i];
            sl[n++] = d[i];
            ones += int'(d[i]);
        end
        if (cfg[3]) begin
            if (cfg[5]) p = ~cfg[4];
            else if (cfg[4]) p = (ones % 2 == 1);
            else p = (ones % 2 == 0);
            sl[n++] = p;
            sl[n++] = p;
        end
        n += !cfg[2] ? 2 : (cfg[1:0] == 2'b00 ? 3 : 4);
        return n;
    endfunction

    // called with the frame already loaded; ends one tick after the last slot
    task automatic check_frame(input logic [7:0] cfg, input logic [7:0] d,
                               input bit pending);
        logic [31:0] sl;
        int t = build(cfg, d, sl);
        for (int s = 0; s < t; s++) begin
            if (s > 0) pulse_tick();
            check(txd == sl[s], "R7", $sformatf("cfg %h slot %0d (R1/R2/R3)", cfg, s),
                  txd, sl[s]);
        end
        check(tx_empty == 1'b0, "R6", "tx_empty in last stop slot", tx_empty, 0);
        pulse_tick();
        if (pending) begin
            check(txd == 1'b0, "R8", "next start after stop", txd, 0);
            check(hold_empty == 1'b1, "R8", "pending byte loaded", hold_empty, 1);
        end else begin
            check(txd == 1'b1, "R2", "idle after stop length", txd, 1);
            check(tx_empty == 1'b1, "R6", "tx_empty after frame", tx_empty, 1);
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check(txd == 1'b1, "R9", "txd in reset", txd, 1);
        check(hold_empty == 1'b1, "R9", "hold_empty in reset", hold_empty, 1);
        check(tx_empty == 1'b1, "R9", "tx_empty in reset", tx_empty, 1);
        rst_n = 1'b1;
        @(negedge clk);
        check(txd == 1'b1, "R9", "txd after reset", txd, 1);

        // ticks while idle: nothing moves (R7)
        pulse_tick();
        pulse_tick();
        check(txd == 1'b1 && tx_empty == 1'b1, "R7", "idle ticks", txd, 1);

        foreach (VEC[k]) begin
            line_cfg = VEC[k][14:8];
            write_byte(VEC[k][7:0]);
            @(negedge clk);
            check(hold_empty == 1'b1, "R5", "empty after load", hold_empty, 1);
            check_frame(VEC[k][15:8], VEC[k][7:0], 1'b0);
        end

        // back to back with a format change between loads (R8)
        line_cfg = 7'h03;
        write_byte(8'h96);
        @(negedge clk);
        line_cfg = 7'h00;
        write_byte(8'h0D);
        check(hold_empty == 1'b0, "R8", "second byte waits", hold_empty, 0);
        check_frame(8'h03, 8'h96, 1'b1);
        check_frame(8'h00, 8'h0D, 1'b0);

        // break while idle and across a frame (R4)
        line_cfg = 7'h43;
        @(negedge clk);
        check(txd == 1'b0, "R4", "break at idle", txd, 0);
        line_cfg = 7'h03;
        write_byte(8'hFF);
        @(negedge clk);
        line_cfg = 7'h43;
        for (int s = 1; s < 20; s++) begin
            pulse_tick();
            check(txd == 1'b0, "R4", $sformatf("break slot %0d", s), txd, 0);
        end
        check(tx_empty == 1'b0, "R4", "frame runs under break", tx_empty, 0);
        pulse_tick();
        check(tx_empty == 1'b1, "R4", "frame ends under break", tx_empty, 1);
        line_cfg = 7'h03;
        @(negedge clk);
        check(txd == 1'b1, "R4", "line after break", txd, 1);

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule